// File: doc/BRIEF.md
# Tagged Branch Target Buffer

This block sits beside the fetch stage of a pipelined processor and guesses the address of the next instruction to fetch. Each fetch PC selects one entry of a direct-mapped table through its low word-address bits. The entry holds the complete address of a branch, the target that branch last jumped to, and a 2-bit saturating confidence counter. The stored target is followed only when the stored address equals the fetch PC in every bit and the counter leans toward taken. In every other case fetch continues at PC+4. The block drives the chosen next PC itself.

When a branch resolves later in the pipeline, the update port reports its address, its outcome and its real target. A taken branch with no entry claims the slot for its index, overwriting whatever was there, and its counter starts at weakly taken. A branch that already has an entry moves its counter one step toward its outcome, and a taken branch with an entry also rewrites the stored target. A branch that was not taken and has no entry leaves the table unchanged.

A lookup takes one clock: the PC presented with `lk_valid` in one cycle produces `pred_valid`, `pred_hit`, `pred_taken` and `next_pc` in the next. Targets sit in a read-first RAM that can map onto block RAM. Valid bits, address tags and counters sit in flops, so that an update can test for a hit in the same cycle it writes.

Top module: `branch_target_buffer`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses with `pred_hit`=0 and `next_pc` = fetch PC + 4.
- R2: A lookup presented with `lk_valid`=1 in cycle t gives `pred_valid`=1 and its result in cycle t+1. In a cycle with no lookup in the previous cycle, `pred_valid`, `pred_hit` and `pred_taken` are 0.
- R3: The entry index is PC bits [IDX_W+1:2] (bits [7:2] at the default of 64 entries). A hit needs the stored branch address to equal the fetch PC in all PC_W bits. A PC that shares an index but differs in any other bit misses.
- R4: On a hit whose counter is 2 or 3, `pred_taken`=1 and `next_pc` is the stored target.
- R5: On a hit whose counter is 0 or 1, `pred_hit`=1, `pred_taken`=0 and `next_pc` = fetch PC + 4.
- R6: A resolved taken branch that misses writes its address and target into its indexed entry, replacing any other branch held there. It sets the counter to 2 (weakly taken).
- R7: A resolved not-taken branch that misses changes no entry.
- R8: A resolved branch that hits moves the counter up by one if taken and down by one if not taken, saturating at 3 and at 0. Counter encoding: 0 strongly not taken, 1 weakly not taken, 2 weakly taken, 3 strongly taken.
- R9: A resolved taken branch that hits replaces the stored target with the reported target.
- R10: A lookup and an update in the same cycle to the same entry give a lookup result from the entry's contents before that update.
- R11: PC+4 wraps modulo 2^PC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | PC_W | Fetch PC to look up |
| upd_valid | input | 1 | Resolved branch report this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_target | input | PC_W | Resolved target address |
| pred_valid | output | 1 | Lookup result valid (one cycle after request) |
| pred_hit | output | 1 | Stored branch address matched the fetch PC |
| pred_taken | output | 1 | Stored target chosen as next PC |
| next_pc | output | PC_W | Predicted next fetch PC |

## Verification
Every one of the 64 indices is first looked up straight after reset and then filled with a taken branch and looked up again. This separates the reset miss path from allocation and from the target path. Addresses that share an index but differ only in high bits, or only in bit 1, show whether the full-address compare or just the index decides a hit. One entry is walked through every counter value and past both saturation ends. Each step shows the edge where the prediction flips between target and PC+4, and whether the ends hold. Further cases cover a miss that is not taken, replacement of a changed target, a lookup colliding with an update to the same entry, and a PC at the top of the address space.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_SNT = 2'd0;
  localparam ctr_t CTR_WT  = 2'd2;
  localparam ctr_t CTR_ST  = 2'd3;
endpackage

// File: rtl/btb_sat_ctr.sv
module btb_sat_ctr
  import btb_pkg::*;
(
  input  ctr_t cur,
  input  logic taken,
  output ctr_t nxt
);
  always_comb begin
    if (taken) nxt = (cur == CTR_ST) ? cur : cur + ctr_t'(1);
    else       nxt = (cur == CTR_SNT) ? cur : cur - ctr_t'(1);
  end
endmodule

// File: rtl/btb_tgt_ram.sv
module btb_tgt_ram #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  // read-first: a same-cycle write is not visible to the read
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
    if (wr_en) mem[wr_addr] <= wr_data;
  end
endmodule

// File: rtl/btb_meta.sv
module btb_meta
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_en,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [PC_W-1:0]  lk_pc,
  output logic             rd_hit,
  output ctr_t             rd_ctr,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic             upd_taken,
  output logic             tgt_we
);
  logic [ENTRIES-1:0] valid_q;
  logic [PC_W-1:0]    tag_q [ENTRIES];
  ctr_t               ctr_q [ENTRIES];

  logic upd_hit, alloc, train;
  ctr_t trained, ctr_wr;

  assign upd_hit = valid_q[upd_idx] && (tag_q[upd_idx] == upd_pc);
  assign alloc   = upd_valid && !upd_hit && upd_taken;
  assign train   = upd_valid && upd_hit;
  assign tgt_we  = alloc || (train && upd_taken);

  btb_sat_ctr u_ctr (
    .cur  (ctr_q[upd_idx]),
    .taken(upd_taken),
    .nxt  (trained)
  );

  assign ctr_wr = alloc ? CTR_WT : trained;

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (alloc) valid_q[upd_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (alloc) tag_q[upd_idx] <= upd_pc;
    if (alloc || train) ctr_q[upd_idx] <= ctr_wr;
  end

  // lookup side reads contents before any same-cycle update
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_hit <= 1'b0;
      rd_ctr <= CTR_SNT;
    end else begin
      rd_hit <= lk_en && valid_q[lk_idx] && (tag_q[lk_idx] == lk_pc);
      rd_ctr <= ctr_q[lk_idx];
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) $past(rst) |-> valid_q == '0);
  // R6
  alloc_weak_chk: assert property (@(posedge clk) disable iff (rst)
    alloc |=> valid_q[$past(upd_idx)] && ctr_q[$past(upd_idx)] == CTR_WT);
  // R7
  no_alloc_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_hit && !upd_taken) |=> $stable(valid_q));
  // R8
  sat_top_chk: assert property (@(posedge clk) disable iff (rst)
    (train && upd_taken && ctr_q[upd_idx] == CTR_ST) |=> ctr_q[$past(upd_idx)] == CTR_ST);
endmodule

// File: rtl/branch_target_buffer.sv
module branch_target_buffer
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target,
  output logic            pred_valid,
  output logic            pred_hit,
  output logic            pred_taken,
  output logic [PC_W-1:0] next_pc
);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_LO + IDX_W - 1;

  logic [IDX_W-1:0] lk_idx, upd_idx;
  logic [PC_W-1:0]  seq_q, tgt_rd;
  logic             hit_rd, tgt_we;
  ctr_t             ctr_rd;

  assign lk_idx  = lk_pc[IDX_HI:IDX_LO];
  assign upd_idx = upd_pc[IDX_HI:IDX_LO];

  btb_meta #(.PC_W(PC_W), .IDX_W(IDX_W)) u_meta (
    .clk      (clk),
    .rst      (rst),
    .lk_en    (lk_valid),
    .lk_idx   (lk_idx),
    .lk_pc    (lk_pc),
    .rd_hit   (hit_rd),
    .rd_ctr   (ctr_rd),
    .upd_valid(upd_valid),
    .upd_idx  (upd_idx),
    .upd_pc   (upd_pc),
    .upd_taken(upd_taken),
    .tgt_we   (tgt_we)
  );

  btb_tgt_ram #(.DATA_W(PC_W), .ADDR_W(IDX_W)) u_ram (
    .clk    (clk),
    .rd_en  (lk_valid),
    .rd_addr(lk_idx),
    .rd_data(tgt_rd),
    .wr_en  (tgt_we),
    .wr_addr(upd_idx),
    .wr_data(upd_target)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid <= 1'b0;
      seq_q      <= '0;
    end else begin
      pred_valid <= lk_valid;
      seq_q      <= lk_pc + PC_W'(4);
    end
  end

  assign pred_hit   = hit_rd;
  assign pred_taken = hit_rd && ctr_rd[1];
  assign next_pc    = pred_taken ? tgt_rd : seq_q;

  // R2
  hit_gated_chk: assert property (@(posedge clk) disable iff (rst)
    pred_hit |-> pred_valid);
  // R5
  taken_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    pred_taken |-> pred_hit);
  // R11
  seq_path_chk: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && !pred_taken) |-> next_pc == $past(lk_pc) + PC_W'(4));
endmodule

// File: tb/branch_target_buffer_tb.sv
`timescale 1ns/1ps
module branch_target_buffer_tb_top;
  localparam int PC_W = 32;
  localparam int IDX_W = 6;
  localparam int N = 1 << IDX_W;

  logic clk = 1'b0, rst = 1'b1;
  logic lk_valid = 0, upd_valid = 0, upd_taken = 0;
  logic [PC_W-1:0] lk_pc = '0, upd_pc = '0, upd_target = '0;
  logic pred_valid, pred_hit, pred_taken;
  logic [PC_W-1:0] next_pc;

  always #2 clk = ~clk;

  branch_target_buffer #(.PC_W(PC_W), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .pred_valid(pred_valid), .pred_hit(pred_hit),
    .pred_taken(pred_taken), .next_pc(next_pc));

  int checks = 0, fails = 0;
  bit done = 0;

  logic            m_v   [N];
  logic [PC_W-1:0] m_tag [N];
  logic [PC_W-1:0] m_tgt [N];
  logic [1:0]      m_ctr [N];

  function automatic int idx_of(logic [PC_W-1:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction

  task automatic expect_pred(string req, logic [PC_W-1:0] pc);
    int i = idx_of(pc);
    logic h = m_v[i] && (m_tag[i] == pc);
    logic t = h && m_ctr[i][1];
    logic [PC_W-1:0] np = t ? m_tgt[i] : pc + 32'd4;
    checks++;
    if (pred_valid !== 1'b1 || pred_hit !== h || pred_taken !== t || next_pc !== np) begin
      fails++;
      $display("FAIL %s pc=%h got v=%b h=%b t=%b np=%h exp v=1 h=%b t=%b np=%h",
               req, pc, pred_valid, pred_hit, pred_taken, next_pc, h, t, np);
    end
  endtask

  task automatic model_update(logic [PC_W-1:0] pc, logic tk, logic [PC_W-1:0] tg);
    int i = idx_of(pc);
    logic h = m_v[i] && (m_tag[i] == pc);
    if (!h && tk) begin
      m_v[i] = 1; m_tag[i] = pc; m_tgt[i] = tg; m_ctr[i] = 2'd2;
    end else if (h) begin
      if (tk) begin
        m_tgt[i] = tg;
        if (m_ctr[i] != 2'd3) m_ctr[i] = m_ctr[i] + 2'd1;
      end else if (m_ctr[i] != 2'd0) m_ctr[i] = m_ctr[i] - 2'd1;
    end
  endtask

  task automatic lookup(string req, logic [PC_W-1:0] pc);
    @(negedge clk); lk_valid = 1; lk_pc = pc;
    @(negedge clk); lk_valid = 0;
    expect_pred(req, pc);
  endtask

  task automatic update(logic [PC_W-1:0] pc, logic tk, logic [PC_W-1:0] tg);
    @(negedge clk); upd_valid = 1; upd_pc = pc; upd_taken = tk; upd_target = tg;
    @(negedge clk); upd_valid = 0;
    model_update(pc, tk, tg);
  endtask

  function automatic logic [PC_W-1:0] pc_at(int i, int hi);
    return (PC_W'(hi) << (IDX_W + 2)) | (PC_W'(i) << 2);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_tag[i] = 0; m_tgt[i] = 0; m_ctr[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    checks++;
    if (pred_valid !== 0 || pred_hit !== 0 || pred_taken !== 0) begin
      fails++; $display("FAIL R2 idle outputs v=%b h=%b t=%b exp 0 0 0", pred_valid, pred_hit, pred_taken);
    end

    // R1: every index misses after reset
    for (int i = 0; i < N; i++) lookup("R1", pc_at(i, 7 + i));

    // R6/R4: allocate every index and hit it
    for (int i = 0; i < N; i++) update(pc_at(i, 7 + i), 1, 32'h4000_0000 + PC_W'(i * 16));
    for (int i = 0; i < N; i++) lookup("R4 R6", pc_at(i, 7 + i));

    // R2: valid drops after a single lookup
    @(negedge clk);
    checks++;
    if (pred_valid !== 0 || pred_hit !== 0) begin
      fails++; $display("FAIL R2 v=%b h=%b exp 0 0", pred_valid, pred_hit);
    end

    // R3: aliases at the same index miss
    for (int i = 0; i < N; i++) lookup("R3", pc_at(i, 900 + i));
    lookup("R3", pc_at(5, 7 + 5) | 32'h2);

    // R5 R8: walk the counter of index 5 down and up
    update(pc_at(5, 12), 0, 0);  lookup("R5 R8", pc_at(5, 12));
    update(pc_at(5, 12), 0, 0);  lookup("R5 R8", pc_at(5, 12));
    update(pc_at(5, 12), 0, 0);  lookup("R8 low sat", pc_at(5, 12));
    update(pc_at(5, 12), 1, 32'h4000_0050); lookup("R8", pc_at(5, 12));
    update(pc_at(5, 12), 1, 32'h4000_0050); lookup("R8", pc_at(5, 12));
    update(pc_at(5, 12), 1, 32'h4000_0050); lookup("R8", pc_at(5, 12));
    update(pc_at(5, 12), 1, 32'h4000_0050); lookup("R8 high sat", pc_at(5, 12));
    update(pc_at(5, 12), 0, 0);  lookup("R8 still taken", pc_at(5, 12));

    // R9: new target overwrites
    update(pc_at(9, 16), 1, 32'h0BAD_F00C); lookup("R9", pc_at(9, 16));

    // R7: untaken miss leaves entry
    update(pc_at(9, 333), 0, 32'h1234_5678); lookup("R7", pc_at(9, 16));
    lookup("R7", pc_at(9, 333));

    // R6: taken miss replaces an aliasing entry
    update(pc_at(9, 333), 1, 32'h2222_2220); lookup("R6", pc_at(9, 333));
    lookup("R6 R3", pc_at(9, 16));

    // R10: same-cycle lookup and update sees old contents
    @(negedge clk);
    lk_valid = 1; lk_pc = pc_at(20, 27);
    upd_valid = 1; upd_pc = pc_at(20, 27); upd_taken = 1; upd_target = 32'h7777_7770;
    @(negedge clk);
    lk_valid = 0; upd_valid = 0;
    expect_pred("R10", pc_at(20, 27));
    model_update(pc_at(20, 27), 1, 32'h7777_7770);
    lookup("R10 after", pc_at(20, 27));

    // R11: sequential wrap
    lookup("R11", 32'hFFFF_FFFC);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule